// File: doc/BRIEF.md
# Global-history bank-selected two-bit branch direction predictor

This block predicts whether a conditional branch is taken. Each entry is a small state machine holding a predicted direction and a flag that records whether the previous prediction for that entry was wrong. The entries sit in several banks. A global history register of recent branch outcomes picks the bank, and a slice of the fetch PC picks the entry inside that bank. The prediction is combinational: a fetch PC presented on the lookup port returns taken or not-taken in the same cycle. The history value used for that prediction is also brought out, so the pipeline can keep it with the branch.

When a branch resolves in execute, the pipeline drives the update port. This port carries the branch PC, the real outcome and the history value that was captured when the prediction was made. The addressed entry steps its state machine, and the outcome is shifted into the global history. Nothing changes at fetch time. The four entry states are `ST_NT_OK` (predict not-taken, last prediction right), `ST_NT_MISS` (predict not-taken, last prediction wrong), `ST_TK_OK` and `ST_TK_MISS`. The transitions are:

- hit: any state moves to the `_OK` state with the same direction.
- first miss: an `_OK` state moves to the `_MISS` state with the same direction.
- second miss: a `_MISS` state moves to the `_OK` state with the opposite direction.

Top module: `hist_sel_predictor`

## Requirements
- R1: After reset every entry in every bank predicts not-taken with the last-right flag, so `lk_taken` is 0 for any PC, and `pred_hist` is 0.
- R2: The entry index is PC bits [IDX_W+1:2]. PC bits [1:0] and all bits above IDX_W+1 have no effect on which entry is read or written.
- R3: The bank read by a lookup is the one whose number equals the current `pred_hist`. Training an entry in one bank leaves the same index in the other banks unchanged.
- R4: An update whose outcome matches the entry's predicted direction keeps the direction and clears the last-wrong flag (entry encoding: bit1 = predicted taken, bit0 = last prediction wrong).
- R5: An update whose outcome differs from the predicted direction while the last-wrong flag is clear keeps the direction and sets the flag.
- R6: An update whose outcome differs from the predicted direction while the last-wrong flag is set inverts the direction and clears the flag.
- R7: On an update the history becomes {pred_hist[HIST_W-2:0], upd_taken} at the next edge. Without an update the history holds its value.
- R8: An update writes the bank named by `upd_hist`, not the bank named by the current history.
- R9: A lookup and an update to the same entry in the same cycle give the lookup the old state. The new state is visible from the following cycle.
- R10: While `upd_valid` is low, the values on the other update inputs change no entry and no history bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Fetch PC to predict |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | HIST_W | Global history used for this lookup |
| upd_valid | input | 1 | A branch resolved this cycle |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| upd_hist | input | HIST_W | History captured when the branch was predicted |

## Verification
The hard case is reading a trained entry back. Every update also moves the global history, so the bank that a lookup reads usually drifts away from the bank that was just trained. The bench handles this by steering the history back to a chosen value with updates to a scratch PC whose index no test uses, before each lookup. The same-cycle case uses a not-taken update from history zero, which leaves the history at zero, so the following lookup reads the same entry that was just rewritten.

// File: rtl/bp_pkg.sv
package bp_pkg;

    // Entry encoding: bit1 = predicted taken, bit0 = last prediction wrong
    typedef enum logic [1:0] {
        ST_NT_OK   = 2'b00,
        ST_NT_MISS = 2'b01,
        ST_TK_OK   = 2'b10,
        ST_TK_MISS = 2'b11
    } bp_state_t;

    // Next state of one entry given the resolved outcome
    function automatic bp_state_t bp_step(bp_state_t cur, logic taken);
        bp_state_t nxt;
        unique case (cur)
            ST_NT_OK:   nxt = taken ? ST_NT_MISS : ST_NT_OK;   // first miss / hit
            ST_NT_MISS: nxt = taken ? ST_TK_OK   : ST_NT_OK;   // second miss flips / hit
            ST_TK_OK:   nxt = taken ? ST_TK_OK   : ST_TK_MISS; // hit / first miss
            ST_TK_MISS: nxt = taken ? ST_TK_OK   : ST_NT_OK;   // hit / second miss flips
            default:    nxt = ST_NT_OK;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/bp_pc_index.sv
module bp_pc_index #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);
    localparam int LO = 2;
    localparam int HI = IDX_W + LO - 1;

    assign idx = pc[HI:LO];

    logic unused_pc_bits;
    assign unused_pc_bits = ^{pc[PC_W-1:HI+1], pc[LO-1:0]};
endmodule

// File: rtl/bp_hist_reg.sv
module bp_hist_reg #(
    parameter int HIST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [HIST_W-1:0] hist
);
    logic [HIST_W-1:0] hist_q;
    logic [HIST_W-1:0] hist_d;

    always_comb begin
        hist_d = hist_q;
        if (shift_en) hist_d = (hist_q << 1) | HIST_W'(bit_in);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end

    assign hist = hist_q;

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(hist_q)); // R10
    AST_HIST_NEWBIT: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> hist_q[0] == $past(bit_in)); // R7
endmodule

// File: rtl/bp_bank.sv
module bp_bank
    import bp_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output bp_state_t        rd_state,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    localparam int DEPTH = 1 << IDX_W;

    bp_state_t ent [DEPTH];
    bp_state_t ent_nxt;

    // state register: table of entry state machines
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ent[i] <= ST_NT_OK;
        end else if (wr_en) begin
            ent[wr_idx] <= ent_nxt;
        end
    end

    // next state and read output
    always_comb begin
        ent_nxt  = bp_step(ent[wr_idx], wr_taken);
        rd_state = ent[rd_idx];
    end

    // checker state: which entry the last write touched
    logic [IDX_W-1:0] chk_idx;
    logic [1:0]       cur_bits;
    logic [1:0]       post_bits;
    always_ff @(posedge clk) chk_idx <= wr_idx;
    assign cur_bits  = ent[wr_idx];
    assign post_bits = ent[chk_idx];

    AST_HIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (cur_bits[1] == wr_taken) |=> post_bits == {$past(wr_taken), 1'b0}); // R4
    AST_MISS1_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (cur_bits[1] != wr_taken) && !cur_bits[0] |=> post_bits == {$past(cur_bits[1]), 1'b1}); // R5
    AST_MISS2_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (cur_bits[1] != wr_taken) && cur_bits[0] |=> post_bits == {$past(wr_taken), 1'b0}); // R6
endmodule

// File: rtl/hist_sel_predictor.sv
module hist_sel_predictor
    import bp_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int IDX_W  = 4,
    parameter int HIST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   lk_pc,
    output logic              lk_taken,
    output logic [HIST_W-1:0] pred_hist,
    input  logic              upd_valid,
    input  logic [PC_W-1:0]   upd_pc,
    input  logic              upd_taken,
    input  logic [HIST_W-1:0] upd_hist
);
    localparam int NBANK = 1 << HIST_W;

    logic [IDX_W-1:0]  lk_idx;
    logic [IDX_W-1:0]  up_idx;
    logic [HIST_W-1:0] hist_q;
    logic [NBANK-1:0]  bank_we;
    bp_state_t         bank_rd [NBANK];
    bp_state_t         lk_state;
    logic [1:0]        lk_bits;

    bp_pc_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_lk_idx (.pc(lk_pc),  .idx(lk_idx));
    bp_pc_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_up_idx (.pc(upd_pc), .idx(up_idx));

    bp_hist_reg #(.HIST_W(HIST_W)) u_hist (
        .clk(clk), .rst_n(rst_n),
        .shift_en(upd_valid), .bit_in(upd_taken), .hist(hist_q)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign bank_we[b] = upd_valid && (upd_hist == HIST_W'(b));
        bp_bank #(.IDX_W(IDX_W)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .rd_idx(lk_idx), .rd_state(bank_rd[b]),
            .wr_en(bank_we[b]), .wr_idx(up_idx), .wr_taken(upd_taken)
        );
    end

    always_comb begin
        lk_state = bank_rd[hist_q];
        lk_bits  = lk_state;
        lk_taken = lk_bits[1];
    end

    assign pred_hist = hist_q;

    AST_ONE_BANK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_we)); // R8
    AST_HIST_SHIFTED: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> pred_hist == (($past(pred_hist) << 1) | HIST_W'($past(upd_taken)))); // R7
    AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |-> bank_we == '0); // R10
endmodule

// File: tb/hist_sel_predictor_tb.sv
module hist_sel_predictor_tb;
    localparam int PC_W = 32;
    localparam int HW   = 2;
    localparam logic [31:0] SCR = 32'h3C; // index 15, scratch only

    logic          clk = 1'b0;
    logic          rst_n;
    logic [31:0]   lk_pc;
    logic          lk_taken;
    logic [HW-1:0] pred_hist;
    logic          upd_valid;
    logic [31:0]   upd_pc;
    logic          upd_taken;
    logic [HW-1:0] upd_hist;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    hist_sel_predictor #(.PC_W(PC_W), .IDX_W(4), .HIST_W(HW)) u_dut (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
        .pred_hist(pred_hist), .upd_valid(upd_valid), .upd_pc(upd_pc),
        .upd_taken(upd_taken), .upd_hist(upd_hist)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one update, driven after a falling edge, returns at the next falling edge
    task automatic do_upd(input logic [31:0] pc, input logic t, input logic [HW-1:0] h);
        upd_pc = pc; upd_taken = t; upd_hist = h; upd_valid = 1'b1;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic set_hist(input logic [HW-1:0] h);
        do_upd(SCR, h[1], pred_hist);
        do_upd(SCR, h[0], pred_hist);
    endtask

    task automatic look(input logic [31:0] pc, output logic tk);
        lk_pc = pc;
        #1;
        tk = lk_taken;
    endtask

    task automatic t_reset();
        logic tk;
        check("R1 hist", int'(pred_hist), 0);
        look(32'h0, tk);        check("R1 pc0", int'(tk), 0);
        look(32'h1234_5678, tk); check("R1 pcX", int'(tk), 0);
        look(32'h3C, tk);       check("R1 pc15", int'(tk), 0);
    endtask

    task automatic t_fsm();
        logic tk;
        // entry A, bank 0
        do_upd(32'h10, 1'b1, 2'd0); set_hist(2'd0);
        look(32'h10, tk); check("R5 first miss keeps NT", int'(tk), 0);
        do_upd(32'h10, 1'b1, 2'd0); set_hist(2'd0);
        look(32'h10, tk); check("R6 second miss flips to T", int'(tk), 1);
        do_upd(32'h10, 1'b0, 2'd0); set_hist(2'd0);
        look(32'h10, tk); check("R5 first miss keeps T", int'(tk), 1);
        do_upd(32'h10, 1'b1, 2'd0);               // hit clears flag
        do_upd(32'h10, 1'b0, 2'd0); set_hist(2'd0);
        look(32'h10, tk); check("R4 hit cleared flag, T kept", int'(tk), 1);
        do_upd(32'h10, 1'b0, 2'd0); set_hist(2'd0);
        look(32'h10, tk); check("R6 second miss flips to NT", int'(tk), 0);
        // entry B, bank 0: miss, hit, miss stays NT
        do_upd(32'h14, 1'b1, 2'd0);
        do_upd(32'h14, 1'b0, 2'd0);
        do_upd(32'h14, 1'b1, 2'd0); set_hist(2'd0);
        look(32'h14, tk); check("R4 NT hit cleared flag", int'(tk), 0);
    endtask

    task automatic t_hist();
        set_hist(2'd0);
        do_upd(SCR, 1'b1, pred_hist); check("R7 shift 1", int'(pred_hist), 1);
        do_upd(SCR, 1'b0, pred_hist); check("R7 shift 0", int'(pred_hist), 2);
        do_upd(SCR, 1'b1, pred_hist); check("R7 shift 1b", int'(pred_hist), 1);
        do_upd(SCR, 1'b1, pred_hist); check("R7 shift 11", int'(pred_hist), 3);
        @(negedge clk);               check("R7 hold", int'(pred_hist), 3);
    endtask

    task automatic t_bank();
        logic tk;
        set_hist(2'd0);
        do_upd(32'h18, 1'b1, 2'd2);
        do_upd(32'h18, 1'b1, 2'd2);
        set_hist(2'd2); look(32'h18, tk); check("R8 bank from upd_hist", int'(tk), 1);
        set_hist(2'd0); look(32'h18, tk); check("R3 bank0 untouched", int'(tk), 0);
        set_hist(2'd1); look(32'h18, tk); check("R3 bank1 untouched", int'(tk), 0);
        set_hist(2'd3); look(32'h18, tk); check("R3 bank3 untouched", int'(tk), 0);
    endtask

    task automatic t_index();
        logic tk;
        do_upd(32'h27, 1'b1, 2'd0);
        do_upd(32'h0010_0024, 1'b1, 2'd0);
        set_hist(2'd0);
        look(32'h24, tk); check("R2 aliased PCs share entry 9", int'(tk), 1);
        look(32'h28, tk); check("R2 neighbour entry 10 untouched", int'(tk), 0);
    endtask

    task automatic t_same_cycle();
        logic tk;
        do_upd(32'hC, 1'b1, 2'd0);
        do_upd(32'hC, 1'b1, 2'd0);
        do_upd(32'hC, 1'b0, 2'd0);               // now taken with flag set
        set_hist(2'd0);
        lk_pc = 32'hC;
        upd_pc = 32'hC; upd_taken = 1'b0; upd_hist = 2'd0; upd_valid = 1'b1;
        #1; check("R9 old state same cycle", int'(lk_taken), 1);
        @(negedge clk); upd_valid = 1'b0;
        #1; check("R9 new state next cycle", int'(lk_taken), 0);
        check("R9 hist stays 0", int'(pred_hist), 0);
        // R10: inputs wiggle while valid is low
        upd_pc = 32'hC; upd_taken = 1'b1; upd_hist = 2'd0;
        repeat (3) @(negedge clk);
        look(32'hC, tk);
        check("R10 entry unchanged", int'(tk), 0);
        check("R10 hist unchanged", int'(pred_hist), 0);
    endtask

    initial begin
        #200000;
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; upd_valid = 1'b0; upd_pc = '0; upd_taken = 1'b0;
        upd_hist = '0; lk_pc = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fsm();
        t_hist();
        t_bank();
        t_index();
        t_same_cycle();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule